// File: doc/BRIEF.md
# Register Rename Map with Move Elimination

This block is the rename stage of an out-of-order core. It takes one decoded instruction per cycle, with two source register numbers, one destination register number, a move flag and a branch flag. It turns these into physical register tags. Sources read the newest mapping of their architectural register. A writing instruction takes a fresh physical register from a circular free list. A register-to-register move takes no new register: its destination is pointed at the physical register that already holds the source value. A per-register reference count tracks how many live mappings share a physical register, so a shared register goes back to the free list only after every mapping that uses it has been released.

One branch checkpoint is held at a time. A two-state controller governs it. In state `CK_NONE` no checkpoint exists. The transition `CK_NONE -> CK_HELD` (take) fires when a branch is renamed: the map, as left by the branch itself, and the free-list head are saved. In `CK_HELD`, the transition `CK_HELD -> CK_NONE` happens either by restore, when a misprediction is signalled, or by release, when the branch is confirmed. On restore, the map goes back to the saved copy, the free-list head goes back to the saved head, and the reference counts lose every effect of later instructions. The commit side returns the previous mapping of each retired write through a release port. Rename publishes that previous mapping for this purpose.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list then hands out tags NARCH..NPHYS-1 in ascending order, so with the defaults the first allocation returns tag 8.
- R2: Source tags are combinational in the same cycle. Each is the newest mapping of its register, read before the instruction's own destination update.
- R3: A non-move instruction with destination not 0 takes the tag at the free-list head, so consecutive writes to one register get different tags. out_pold gives the destination's mapping before this instruction.
- R4: Architectural register 0 is never renamed. A source 0 reads tag 0. Destination 0 allocates nothing and gives out_pdst 0.
- R5: A move (in_is_move=1) with source A not 0 and destination not 0 gives out_pdst equal to the mapping of source A. It pops nothing and adds one to that tag's count. If the count is saturated, or source A is 0, the move allocates like an ordinary write.
- R6: Renaming a branch saves the map as updated by the branch itself, plus the free-list head. A recovery pulse while a checkpoint is held restores that map by the next cycle.
- R7: Tags allocated after the checkpointed branch are reclaimed by a recovery. They are handed out again first, in their original order.
- R8: Only one checkpoint exists. A branch presented while one is held stalls.
- R9: A confirm pulse drops the held checkpoint. A recovery pulse with no checkpoint is ignored. A recovery pulse with a checkpoint stalls any instruction in that cycle.
- R10: A release (cm_valid with cm_tag) lowers that tag's count. The tag is appended to the free-list tail when its count reaches zero, so a tag shared by a move needs two releases. A release of tag 0 or of a tag whose count is zero has no effect.
- R11: Rename stalls when the free list is empty and the instruction needs a new tag. A move that needs no tag still proceeds while the list is empty.
- R12: out_fire equals in_valid and not stall. The map, counts and free list change only on a fired instruction, a release, or a checkpoint event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_src_a | input | 3 | Source A register; the source of a move |
| in_src_b | input | 3 | Source B register |
| in_dst | input | 3 | Destination register (0 = none) |
| in_is_move | input | 1 | Instruction is a register move |
| in_is_branch | input | 1 | Instruction is a branch to checkpoint |
| br_recover | input | 1 | Misprediction: restore checkpoint |
| br_confirm | input | 1 | Branch correct: drop checkpoint |
| cm_valid | input | 1 | Commit releases a tag |
| cm_tag | input | 5 | Tag released by commit |
| out_psrc_a | output | 5 | Physical tag of source A |
| out_psrc_b | output | 5 | Physical tag of source B |
| out_pdst | output | 5 | Physical tag given to the destination |
| out_pold | output | 5 | Previous mapping of the destination |
| out_fire | output | 1 | Instruction renamed this cycle |
| stall | output | 1 | Instruction held back this cycle |

## Verification
Most internal faults show up on the source and destination tags. A wrong map entry appears on the very next source read of that register. A free-list pointer fault appears on the next allocation as a repeated or out-of-order tag. A reference-count fault is slower to show: a shared tag comes back too early or never, which becomes visible only when the free list drains to that tag or runs empty. The bench therefore drains the list completely after mixed moves, recoveries and releases. It compares every tag handed out against an order computed from the requirements.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [0:0] {
        CK_NONE = 1'b0,
        CK_HELD = 1'b1
    } ck_state_e;
endpackage

// File: rtl/rn_ctrl.sv
module rn_ctrl
    import rn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic br_fire,
    input  logic recover,
    input  logic confirm,
    output logic held,
    output logic restore,
    output logic clear
);
    ck_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CK_NONE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CK_NONE: if (br_fire)            state_nx = CK_HELD;
            CK_HELD: if (recover || confirm) state_nx = CK_NONE;
            default:                         state_nx = CK_NONE;
        endcase
    end

    always_comb begin
        held    = 1'b0;
        restore = 1'b0;
        clear   = 1'b0;
        unique case (state)
            CK_NONE: ;
            CK_HELD: begin
                held    = 1'b1;
                restore = recover;
                clear   = recover || confirm;
            end
            default: ;
        endcase
    end

    // R6: a recovery while holding always returns to CK_NONE
    assert_restore_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CK_HELD && recover) |=> (state == CK_NONE));
endmodule

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int NARCH = 8,
    parameter int NPHYS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pop,
    input  logic                     push,
    input  logic [$clog2(NPHYS)-1:0] push_tag,
    input  logic                     ckpt,
    input  logic                     restore,
    output logic [$clog2(NPHYS)-1:0] head_tag,
    output logic                     empty
);
    localparam int PW    = $clog2(NPHYS);
    localparam int IW    = PW + 1;
    localparam int NFREE = NPHYS - NARCH;

    logic [PW-1:0] ring [NPHYS];
    logic [IW-1:0] head, tail, ck_head;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++)
                ring[i] <= (i < NFREE) ? PW'(i + NARCH) : '0;
            head    <= '0;
            tail    <= IW'(NFREE);
            ck_head <= '0;
        end else begin
            if (push) begin
                ring[tail[PW-1:0]] <= push_tag;
                tail               <= tail + IW'(1);
            end
            if (restore)  head <= ck_head;
            else if (pop) head <= head + IW'(1);
            if (ckpt) ck_head <= pop ? head + IW'(1) : head;
        end
    end

    assign head_tag = ring[head[PW-1:0]];
    assign empty    = (head == tail);

    // R11: nothing is taken from an empty list
    assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rn_refcnt.sv
module rn_refcnt #(
    parameter int NARCH = 8,
    parameter int NPHYS = 32,
    parameter int CW    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc,
    input  logic [$clog2(NPHYS)-1:0] alloc_tag,
    input  logic                     inc,
    input  logic [$clog2(NPHYS)-1:0] inc_tag,
    input  logic                     spec,
    input  logic                     rel,
    input  logic [$clog2(NPHYS)-1:0] rel_tag,
    input  logic                     restore,
    input  logic                     clear,
    input  logic [$clog2(NPHYS)-1:0] q_tag,
    output logic                     q_sat,
    output logic                     free_push,
    output logic [$clog2(NPHYS)-1:0] free_tag
);
    localparam int PW = $clog2(NPHYS);

    logic [CW-1:0] cnt   [NPHYS];
    logic [CW-1:0] sinc  [NPHYS];
    logic          salloc[NPHYS];
    logic [CW-1:0] nxt   [NPHYS];
    logic          rel_ok;

    assign rel_ok = rel && (rel_tag != '0) && (cnt[rel_tag] != '0);

    always_comb begin
        for (int p = 0; p < NPHYS; p++) begin
            nxt[p] = cnt[p];
            if (restore) nxt[p] = salloc[p] ? '0 : cnt[p] - sinc[p];
            if (inc && inc_tag == PW'(p))    nxt[p] = nxt[p] + CW'(1);
            if (rel_ok && rel_tag == PW'(p)) nxt[p] = nxt[p] - CW'(1);
            if (alloc && alloc_tag == PW'(p)) nxt[p] = CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPHYS; p++) begin
                cnt[p]    <= (p != 0 && p < NARCH) ? CW'(1) : '0;
                sinc[p]   <= '0;
                salloc[p] <= 1'b0;
            end
        end else begin
            for (int p = 0; p < NPHYS; p++) begin
                cnt[p] <= nxt[p];
                if (clear) begin
                    sinc[p]   <= '0;
                    salloc[p] <= 1'b0;
                end else begin
                    if (spec && inc && inc_tag == PW'(p))     sinc[p]   <= sinc[p] + CW'(1);
                    if (spec && alloc && alloc_tag == PW'(p)) salloc[p] <= 1'b1;
                end
            end
        end
    end

    assign q_sat     = &cnt[q_tag];
    assign free_push = rel_ok && (nxt[rel_tag] == '0);
    assign free_tag  = rel_tag;

    // R3: a tag handed out by the free list carries no live mapping
    assert_alloc_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (cnt[alloc_tag] == '0));
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
    parameter int NARCH = 8,
    parameter int NPHYS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [$clog2(NARCH)-1:0] wr_arch,
    input  logic [$clog2(NPHYS)-1:0] wr_tag,
    input  logic                     ckpt,
    input  logic                     restore,
    input  logic [$clog2(NARCH)-1:0] ra,
    input  logic [$clog2(NARCH)-1:0] rb,
    input  logic [$clog2(NARCH)-1:0] rd,
    output logic [$clog2(NPHYS)-1:0] ta,
    output logic [$clog2(NPHYS)-1:0] tb,
    output logic [$clog2(NPHYS)-1:0] td
);
    localparam int AW = $clog2(NARCH);
    localparam int PW = $clog2(NPHYS);

    logic [PW-1:0] map [NARCH];
    logic [PW-1:0] ck  [NARCH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++) begin
                map[i] <= PW'(i);
                ck[i]  <= PW'(i);
            end
        end else begin
            for (int i = 0; i < NARCH; i++) begin
                if (restore)                        map[i] <= ck[i];
                else if (wr && wr_arch == AW'(i))   map[i] <= wr_tag;
                if (ckpt) ck[i] <= (wr && wr_arch == AW'(i)) ? wr_tag : map[i];
            end
        end
    end

    assign ta = (ra == '0) ? '0 : map[ra];
    assign tb = (rb == '0) ? '0 : map[rb];
    assign td = (rd == '0) ? '0 : map[rd];
endmodule

// File: rtl/rename_map.sv
module rename_map #(
    parameter int NARCH = 8,
    parameter int NPHYS = 32,
    parameter int CW    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [$clog2(NARCH)-1:0] in_src_a,
    input  logic [$clog2(NARCH)-1:0] in_src_b,
    input  logic [$clog2(NARCH)-1:0] in_dst,
    input  logic                     in_is_move,
    input  logic                     in_is_branch,
    input  logic                     br_recover,
    input  logic                     br_confirm,
    input  logic                     cm_valid,
    input  logic [$clog2(NPHYS)-1:0] cm_tag,
    output logic [$clog2(NPHYS)-1:0] out_psrc_a,
    output logic [$clog2(NPHYS)-1:0] out_psrc_b,
    output logic [$clog2(NPHYS)-1:0] out_pdst,
    output logic [$clog2(NPHYS)-1:0] out_pold,
    output logic                     out_fire,
    output logic                     stall
);
    localparam int PW = $clog2(NPHYS);

    logic          held, restore, clear, empty, q_sat;
    logic          need, hold_back, alloc, alias_mv, wr, br_fire;
    logic          free_push;
    logic [PW-1:0] ta, tb, td, head_tag, wr_tag, free_tag;

    assign need      = (in_dst != '0) && !(in_is_move && (in_src_a != '0) && !q_sat);
    assign hold_back = restore || (in_is_branch && held) || (need && empty);
    assign stall     = in_valid && hold_back;
    assign out_fire  = in_valid && !hold_back;
    assign alloc     = out_fire && need;
    assign alias_mv  = out_fire && (in_dst != '0) && !need;
    assign wr        = out_fire && (in_dst != '0);
    assign br_fire   = out_fire && in_is_branch;
    assign wr_tag    = need ? head_tag : ta;

    assign out_psrc_a = ta;
    assign out_psrc_b = tb;
    assign out_pold   = td;
    assign out_pdst   = (in_dst == '0) ? '0 : wr_tag;

    rn_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .br_fire(br_fire), .recover(br_recover),
        .confirm(br_confirm), .held(held), .restore(restore), .clear(clear)
    );

    rn_maptable #(.NARCH(NARCH), .NPHYS(NPHYS)) u_map (
        .clk(clk), .rst_n(rst_n), .wr(wr), .wr_arch(in_dst), .wr_tag(wr_tag),
        .ckpt(br_fire), .restore(restore), .ra(in_src_a), .rb(in_src_b),
        .rd(in_dst), .ta(ta), .tb(tb), .td(td)
    );

    rn_freelist #(.NARCH(NARCH), .NPHYS(NPHYS)) u_free (
        .clk(clk), .rst_n(rst_n), .pop(alloc), .push(free_push),
        .push_tag(free_tag), .ckpt(br_fire), .restore(restore),
        .head_tag(head_tag), .empty(empty)
    );

    rn_refcnt #(.NARCH(NARCH), .NPHYS(NPHYS), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .alloc(alloc), .alloc_tag(head_tag),
        .inc(alias_mv), .inc_tag(ta), .spec(held), .rel(cm_valid),
        .rel_tag(cm_tag), .restore(restore), .clear(clear), .q_tag(ta),
        .q_sat(q_sat), .free_push(free_push), .free_tag(free_tag)
    );

    // R3: back-to-back allocations never repeat a tag
    assert_fresh_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (!alloc || out_pdst != $past(out_pdst)));
    // R4: register 0 always reads tag 0
    assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_src_a == '0) |-> (out_psrc_a == '0));
    // R5: an eliminated move aliases its source tag
    assert_move_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && in_is_move && in_src_a != '0 && in_dst != '0 && !q_sat)
            |-> (out_pdst == out_psrc_a));
    // R8: a second branch cannot pass while a checkpoint is held
    assert_one_ckpt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_branch && held) |-> stall);
endmodule

// File: tb/rename_map_bench.sv
`timescale 1ns/1ps
module rename_map_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_is_move = 1'b0, in_is_branch = 1'b0;
    logic [2:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic       br_recover = 1'b0, br_confirm = 1'b0, cm_valid = 1'b0;
    logic [4:0] cm_tag = '0;
    logic [4:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;
    logic       out_fire, stall;

    always #2.5 clk = ~clk;

    rename_map u_rename_map (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst(in_dst), .in_is_move(in_is_move),
        .in_is_branch(in_is_branch), .br_recover(br_recover),
        .br_confirm(br_confirm), .cm_valid(cm_valid), .cm_tag(cm_tag),
        .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b), .out_pdst(out_pdst),
        .out_pold(out_pold), .out_fire(out_fire), .stall(stall)
    );

    typedef struct packed {
        logic       stl;
        logic [4:0] psa, psb, pdst, pold;
    } exp_t;

    exp_t  sbq[$];
    string reqq[$];
    int    nchk = 0, nfail = 0;

    // reference model state
    int mmap[8], ckmap[8], refc[32], ckref[32];
    int fl[$], spl[$];
    bit held = 1'b0;

    // monitor: compare each scoreboard item shortly before the rising edge
    always @(negedge clk) begin
        #1.5;
        if (sbq.size() > 0) begin
            exp_t  e;
            string r;
            bit    ok;
            e = sbq.pop_front();
            r = reqq.pop_front();
            ok = (stall == e.stl) && (out_fire == !e.stl);   // R12
            if (!e.stl)
                ok = ok && out_psrc_a == e.psa && out_psrc_b == e.psb &&
                     out_pdst == e.pdst && out_pold == e.pold;
            nchk++;
            if (!ok) begin
                nfail++;
                $display("FAIL %s: got stall=%0b fire=%0b a=%0d b=%0d d=%0d old=%0d exp stall=%0b a=%0d b=%0d d=%0d old=%0d",
                         r, stall, out_fire, out_psrc_a, out_psrc_b, out_pdst, out_pold,
                         e.stl, e.psa, e.psb, e.pdst, e.pold);
            end
        end
    end

    task automatic ren(input int sa, input int sb, input int d, input bit mv,
                       input bit br, input bit rec, input string req);
        exp_t e;
        bit   need, stl;
        int   t;
        @(negedge clk);
        need = (d != 0) && !(mv && sa != 0 && refc[mmap[sa]] < 15);
        stl  = (rec && held) || (br && held) || (need && fl.size() == 0);
        e.stl  = stl;
        e.psa  = 5'(mmap[sa]);
        e.psb  = 5'(mmap[sb]);
        e.pold = 5'(mmap[d]);
        e.pdst = (d == 0) ? 5'd0 : (need ? ((fl.size() > 0) ? 5'(fl[0]) : 5'd0) : 5'(mmap[sa]));
        sbq.push_back(e);
        reqq.push_back(req);
        in_valid = 1'b1; in_src_a = 3'(sa); in_src_b = 3'(sb); in_dst = 3'(d);
        in_is_move = mv; in_is_branch = br; br_recover = rec;
        @(posedge clk);
        if (rec && held) begin
            mmap = ckmap;
            refc = ckref;
            for (int i = spl.size() - 1; i >= 0; i--) fl.push_front(spl[i]);
            spl.delete();
            held = 1'b0;
        end else if (!stl) begin
            if (d != 0) begin
                if (need) begin
                    t = fl.pop_front();
                    refc[t] = 1;
                    if (held) spl.push_back(t);
                end else begin
                    t = mmap[sa];
                    refc[t]++;
                end
                mmap[d] = t;
            end
            if (br) begin
                ckmap = mmap;
                ckref = refc;
                spl.delete();
                held = 1'b1;
            end
        end
        #1;
        in_valid = 1'b0; br_recover = 1'b0; in_is_branch = 1'b0; in_is_move = 1'b0;
    endtask

    task automatic release_tag(input int tag);
        @(negedge clk);
        cm_valid = 1'b1; cm_tag = 5'(tag);
        @(posedge clk);
        if (tag != 0 && refc[tag] > 0) begin
            refc[tag]--;
            if (held) ckref[tag]--;
            if (refc[tag] == 0) fl.push_back(tag);
        end
        #1;
        cm_valid = 1'b0;
    endtask

    task automatic confirm_br();
        @(negedge clk);
        br_confirm = 1'b1;
        @(posedge clk);
        held = 1'b0;
        spl.delete();
        #1;
        br_confirm = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        nfail++; nchk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mmap[i] = i;
        for (int p = 0; p < 32; p++) refc[p] = (p != 0 && p < 8) ? 1 : 0;
        for (int p = 8; p < 32; p++) fl.push_back(p);
        ckmap = mmap; ckref = refc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1.5;
        nchk++;   // R1 / R12: idle after reset
        if (stall !== 1'b0 || out_fire !== 1'b0) begin
            nfail++;
            $display("FAIL R1: idle stall=%0b fire=%0b expected 0 0", stall, out_fire);
        end

        ren(1, 2, 3, 0, 0, 0, "R1 first allocation");
        ren(3, 3, 3, 0, 0, 0, "R2 newest mapping read");
        ren(0, 0, 0, 0, 0, 0, "R4 register zero");
        ren(3, 0, 5, 1, 0, 0, "R5 move aliases");
        ren(5, 4, 6, 0, 0, 0, "R5 move popped nothing");
        ren(0, 0, 7, 1, 0, 0, "R5 move from zero allocates");
        ren(6, 1, 2, 0, 1, 0, "R6 branch renamed");
        ren(2, 2, 2, 0, 0, 0, "R3 speculative write");
        ren(3, 0, 4, 1, 0, 0, "R5 speculative move");
        ren(1, 1, 1, 0, 0, 0, "R3 speculative write");
        ren(1, 1, 1, 0, 1, 0, "R8 second branch stalls");
        ren(1, 1, 6, 0, 0, 1, "R9 recovery stalls input");
        ren(2, 1, 3, 0, 0, 0, "R7 reclaimed tag reused");
        ren(4, 1, 1, 0, 0, 0, "R6 restored map");
        ren(3, 2, 2, 0, 1, 0, "R6 new branch");
        confirm_br();
        ren(2, 0, 6, 0, 0, 1, "R9 recovery without checkpoint ignored");
        ren(2, 6, 0, 0, 0, 0, "R9 map kept after confirm");
        release_tag(9);
        release_tag(0);
        release_tag(9);
        release_tag(8);
        while (fl.size() > 0) ren(1, 2, 3, 0, 0, 0, "R10 drain order");
        ren(1, 2, 7, 0, 0, 0, "R11 empty list stalls");
        ren(3, 0, 5, 1, 0, 0, "R11 move proceeds when empty");
        release_tag(mmap[6]);
        ren(6, 0, 4, 0, 0, 0, "R10 released tag allocated");
        ren(1, 2, 7, 0, 0, 0, "R11 empty again stalls");
        @(negedge clk); @(negedge clk); #2;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule